// File: doc/BRIEF.md
# Dual Parallel Port Handshake Controller

This block drives two parallel ports, A and B, each W bits wide, and moves data between a host register bus and a peripheral with a ready/strobe handshake. The host reaches four registers, a data and a command register per port, through chip select, single-cycle read and write strobes, a port select and a data/command select. Each port has a data output latch, a data input latch, a mode, an interrupt enable and a pending interrupt flag. Pins are not tristated here: each port has separate input, output and per-bit output-enable vectors.

A port runs in one of four modes: handshake output, handshake input, bidirectional (port A only) and bit-control. In the handshake modes a ready flag tells the peripheral that fresh data waits, or that the port can take data, and the rising edge of the peripheral's active-low strobe ends the transfer. In bidirectional mode port A takes over port B's ready/strobe pair for its input direction, which leaves port B with bit-control as its only usable mode. In bit-control mode each bit has its own direction, and a programmable match on the input bits raises the interrupt request.

Top module: `ppio_ctrl`

## Requirements
- R1: After synchronous reset both ports are in handshake input mode with both ready outputs low, both interrupt requests low, all output enables low and both input latches zero.
- R2: A command byte with bits[1:0]=11 selects the mode from bits[7:6] (0 output, 1 input, 2 bidirectional, 3 bit-control), the match rule from bit5 (1 all watched bits, 0 any watched bit) and the active level from bit4 (1 high, 0 low); a byte with bits[1:0]=01 sets the interrupt enable to bit7, and a 0 there also drops a pending request; any other command byte changes nothing.
- R3: In output mode a data write loads the output latch, which drives the pins with every output enable high, and the ready output is high from the cycle after the write.
- R4: A transfer ends on the clock edge where the strobe is seen high after being low: the ready output drops there, and the interrupt request rises there only if interrupts are enabled.
- R5: In input mode the pins are latched every cycle the strobe is low; entering the mode or reading the data register sets the ready output, and the read returns the latched byte.
- R6: In bidirectional mode port A drives its pins (all enables high) only while its own strobe is low, its ready output follows its output side, port B's strobe latches port A's pins into port A's input latch, and port B's ready output shows port A's input-side ready.
- R7: Port B ignores a request for bidirectional mode, and while port A is bidirectional port B ignores every mode request other than bit-control.
- R8: After a bit-control mode byte the next command byte to that port is the direction mask (1 = input, output enable low) and the one after it the watch mask (1 = watched); a data read returns pin values on input bits and latch values on output bits.
- R9: In bit-control mode a match is evaluated only over bits that are both watched and inputs, and the interrupt request rises on the cycle the match turns from false to true when interrupts are enabled.
- R10: A read or write of a port's data register clears that port's pending interrupt request unless a new event sets it in the same cycle.
- R11: An accepted mode byte clears the port's output-side ready, and in bit-control mode the port's ready output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Register access select |
| wr | input | 1 | Single-cycle write strobe |
| rd | input | 1 | Single-cycle read strobe |
| sel_port | input | 1 | 0 port A, 1 port B |
| sel_cmd | input | 1 | 0 data register, 1 command register |
| wdata | input | W | Write data |
| rdata | output | W | Read data, zero when no data read |
| a_in | input | W | Port A pin values |
| a_out | output | W | Port A output latch |
| a_oe | output | W | Port A per-bit output enable |
| a_stb_n | input | 1 | Port A strobe from peripheral, active low |
| a_rdy | output | 1 | Port A ready to peripheral |
| b_in | input | W | Port B pin values |
| b_out | output | W | Port B output latch |
| b_oe | output | W | Port B per-bit output enable |
| b_stb_n | input | 1 | Port B strobe from peripheral, active low |
| b_rdy | output | 1 | Port B ready to peripheral |
| irq_a | output | 1 | Port A interrupt request |
| irq_b | output | 1 | Port B interrupt request |

## Verification
The bench builds the block at its default width of eight bits, where the mode, match-rule and level fields of the command byte fit and every mode is reachable on both ports. At that width the direction and watch masks can split a port into an input nibble and an output nibble, so one pattern shows a low output bit being left out of an active-low match while an input bit in the same port triggers it. It also reaches the lock of port B while port A is bidirectional and the release when port A returns to output mode.

// File: rtl/ppio_pkg.sv
// Shared types for the parallel port controller.
// Assumes command bytes are at least 8 bits wide.
package ppio_pkg;
    typedef enum logic [1:0] {
        MD_OUT   = 2'd0,
        MD_IN    = 2'd1,
        MD_BIDIR = 2'd2,
        MD_BIT   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        CF_IDLE = 2'd0,
        CF_DIR  = 2'd1,
        CF_MASK = 2'd2
    } cfg_e;

    localparam logic [1:0] TAG_MODE = 2'b11;
    localparam logic [1:0] TAG_IEN  = 2'b01;
    localparam int MODE_HI  = 7;
    localparam int MODE_LO  = 6;
    localparam int RULE_BIT = 5;
    localparam int LVL_BIT  = 4;
    localparam int IEN_BIT  = 7;
endpackage

// File: rtl/ppio_match.sv
// Bit-control match detector. Watches only bits that are both inputs
// and selected in the watch mask; assumes the masks are stable inputs.
module ppio_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] pins,
    input  logic [W-1:0] dir_mask,
    input  logic [W-1:0] mon_mask,
    input  logic         use_and,
    input  logic         act_high,
    output logic         hit
);
    logic [W-1:0] watch;
    logic [W-1:0] act;

    // Evaluate the all/any rule over active-level watched inputs.
    always_comb begin
        watch = mon_mask & dir_mask;
        act   = act_high ? pins : ~pins;
        hit   = (|watch) && (use_and ? ((act & watch) == watch) : (|(act & watch)));
    end
endmodule

// File: rtl/ppio_port.sv
// One port: mode and mask registers, data latches, ready flags for the
// output and input directions, strobe edge detection and interrupt flag.
// Assumes strobes are synchronous to clk and bus strobes last one cycle.
module ppio_port
    import ppio_pkg::*;
#(
    parameter int W        = 8,
    parameter bit BIDIR_OK = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lock_hs,
    input  logic         wr_data,
    input  logic         wr_cmd,
    input  logic         rd_data,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pins_in,
    input  logic         out_stb_n,
    input  logic         in_stb_n,
    output logic [W-1:0] pins_out,
    output logic [W-1:0] pins_oe,
    output logic [W-1:0] rd_val,
    output logic         rdy_o,
    output logic         rdy_i,
    output logic         irq,
    output mode_e        mode
);
    logic [W-1:0] out_latch, in_latch, dir_mask, mon_mask;
    logic         use_and, act_high, ien;
    cfg_e         cfg;
    logic         ostb_q, istb_q, hit, hit_q;
    logic         bidir_allow;
    mode_e        new_mode;
    logic         mode_ok, ien_wr, uses_out, uses_in;
    logic         o_done, i_done, m_rise;

    // Parameter picks whether this port may enter bidirectional mode.
    if (BIDIR_OK) begin : g_bidir
        assign bidir_allow = 1'b1;
    end else begin : g_nobidir
        assign bidir_allow = 1'b0;
    end

    ppio_match #(.W(W)) u_match (
        .pins     (pins_in),
        .dir_mask (dir_mask),
        .mon_mask (mon_mask),
        .use_and  (use_and),
        .act_high (act_high),
        .hit      (hit)
    );

    // Decode command writes and handshake events.
    always_comb begin
        new_mode = mode_e'(wdata[MODE_HI:MODE_LO]);
        mode_ok  = wr_cmd && (cfg == CF_IDLE) && (wdata[1:0] == TAG_MODE)
                   && !(new_mode == MD_BIDIR && !bidir_allow)
                   && !(lock_hs && new_mode != MD_BIT);
        ien_wr   = wr_cmd && (cfg == CF_IDLE) && (wdata[1:0] == TAG_IEN);
        uses_out = (mode == MD_OUT) || (mode == MD_BIDIR);
        uses_in  = (mode == MD_IN)  || (mode == MD_BIDIR);
        o_done   = uses_out && out_stb_n && !ostb_q;
        i_done   = uses_in  && in_stb_n  && !istb_q;
        m_rise   = (mode == MD_BIT) && hit && !hit_q;
    end

    // Mode word, follow-on masks and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MD_IN;
            use_and  <= 1'b0;
            act_high <= 1'b0;
            ien      <= 1'b0;
            dir_mask <= '1;
            mon_mask <= '0;
            cfg      <= CF_IDLE;
        end else if (wr_cmd) begin
            if (cfg == CF_DIR) begin
                dir_mask <= wdata;
                cfg      <= CF_MASK;
            end else if (cfg == CF_MASK) begin
                mon_mask <= wdata;
                cfg      <= CF_IDLE;
            end else if (mode_ok) begin
                mode     <= new_mode;
                use_and  <= wdata[RULE_BIT];
                act_high <= wdata[LVL_BIT];
                cfg      <= (new_mode == MD_BIT) ? CF_DIR : CF_IDLE;
            end else if (ien_wr) begin
                ien <= wdata[IEN_BIT];
            end
        end
    end

    // Data latches: output on host write, input while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_latch <= '0;
            in_latch  <= '0;
        end else begin
            if (wr_data) out_latch <= wdata;
            if (uses_in && !in_stb_n) in_latch <= pins_in;
        end
    end

    // Previous strobe and match samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ostb_q <= 1'b1;
            istb_q <= 1'b1;
            hit_q  <= 1'b0;
        end else begin
            ostb_q <= out_stb_n;
            istb_q <= in_stb_n;
            hit_q  <= hit && (mode == MD_BIT);
        end
    end

    // Ready flags for the output and input directions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_o <= 1'b0;
            rdy_i <= 1'b0;
        end else if (mode_ok) begin
            rdy_o <= 1'b0;
            rdy_i <= (new_mode == MD_IN) || (new_mode == MD_BIDIR);
        end else begin
            if (wr_data && uses_out) rdy_o <= 1'b1;
            else if (o_done)         rdy_o <= 1'b0;
            if (rd_data && uses_in)  rdy_i <= 1'b1;
            else if (i_done)         rdy_i <= 1'b0;
        end
    end

    // Interrupt request: set by events, cleared by data access or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (ien && (o_done || i_done || m_rise)) begin
            irq <= 1'b1;
        end else if (wr_data || rd_data || (ien_wr && !wdata[IEN_BIT])) begin
            irq <= 1'b0;
        end
    end

    // Pin drive and read-back value per mode.
    always_comb begin
        pins_out = out_latch;
        case (mode)
            MD_OUT:   pins_oe = '1;
            MD_BIDIR: pins_oe = {W{!out_stb_n}};
            MD_BIT:   pins_oe = ~dir_mask;
            default:  pins_oe = '0;
        endcase
        case (mode)
            MD_OUT:  rd_val = out_latch;
            MD_BIT:  rd_val = (pins_in & dir_mask) | (out_latch & ~dir_mask);
            default: rd_val = in_latch;
        endcase
    end
endmodule

// File: rtl/ppio_ctrl.sv
// Top of the dual parallel port controller. Decodes the register bus,
// instantiates both ports and routes port B's handshake pair to port A
// while port A is bidirectional. Assumes single-cycle rd/wr strobes.
module ppio_ctrl
    import ppio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs,
    input  logic         wr,
    input  logic         rd,
    input  logic         sel_port,
    input  logic         sel_cmd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic         a_stb_n,
    output logic         a_rdy,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    input  logic         b_stb_n,
    output logic         b_rdy,
    output logic         irq_a,
    output logic         irq_b
);
    logic         wd_a, wc_a, rd_a, wd_b, wc_b, rd_b;
    logic         a_bidir, a_in_stb_n, b_hs_stb_n;
    logic         a_rdy_o, a_rdy_i, b_rdy_o, b_rdy_i;
    logic [W-1:0] a_val, b_val;
    mode_e        a_mode, b_mode;

    // Register bus decode into per-port strobes.
    always_comb begin
        wd_a = cs && wr && !sel_cmd && !sel_port;
        wc_a = cs && wr &&  sel_cmd && !sel_port;
        rd_a = cs && rd && !sel_cmd && !sel_port;
        wd_b = cs && wr && !sel_cmd &&  sel_port;
        wc_b = cs && wr &&  sel_cmd &&  sel_port;
        rd_b = cs && rd && !sel_cmd &&  sel_port;
    end

    // Handshake pin routing between the two ports.
    always_comb begin
        a_bidir    = (a_mode == MD_BIDIR);
        a_in_stb_n = a_bidir ? b_stb_n : a_stb_n;
        b_hs_stb_n = a_bidir ? 1'b1 : b_stb_n;
        a_rdy      = a_rdy_o || (a_rdy_i && !a_bidir);
        b_rdy      = a_bidir ? a_rdy_i : (b_rdy_o || b_rdy_i);
        rdata      = (cs && rd && !sel_cmd) ? (sel_port ? b_val : a_val) : '0;
    end

    ppio_port #(.W(W), .BIDIR_OK(1'b1)) u_port_a (
        .clk(clk), .rst_n(rst_n), .lock_hs(1'b0),
        .wr_data(wd_a), .wr_cmd(wc_a), .rd_data(rd_a), .wdata(wdata),
        .pins_in(a_in), .out_stb_n(a_stb_n), .in_stb_n(a_in_stb_n),
        .pins_out(a_out), .pins_oe(a_oe), .rd_val(a_val),
        .rdy_o(a_rdy_o), .rdy_i(a_rdy_i), .irq(irq_a), .mode(a_mode)
    );

    ppio_port #(.W(W), .BIDIR_OK(1'b0)) u_port_b (
        .clk(clk), .rst_n(rst_n), .lock_hs(a_bidir),
        .wr_data(wd_b), .wr_cmd(wc_b), .rd_data(rd_b), .wdata(wdata),
        .pins_in(b_in), .out_stb_n(b_hs_stb_n), .in_stb_n(b_hs_stb_n),
        .pins_out(b_out), .pins_oe(b_oe), .rd_val(b_val),
        .rdy_o(b_rdy_o), .rdy_i(b_rdy_i), .irq(irq_b), .mode(b_mode)
    );
endmodule

// File: rtl/ppio_ctrl_sva.sv
// Property checker for ppio_ctrl, bound to every instance of the top.
module ppio_ctrl_sva #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs,
    input logic         wr,
    input logic         sel_port,
    input logic         sel_cmd,
    input logic         a_stb_n,
    input logic         a_rdy,
    input logic         b_rdy,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_oe,
    input logic         irq_a,
    input logic         irq_b,
    input logic [1:0]   a_mode,
    input logic [1:0]   b_mode
);
    logic a_wr_any;
    assign a_wr_any = cs && wr && !sel_port;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!a_rdy && !b_rdy && !irq_a && !irq_b && a_oe == '0 && b_oe == '0));

    p_write_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !sel_cmd && !sel_port && a_mode == 2'd0) |=> a_rdy);

    p_strobe_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_mode == 2'd0 && $rose(a_stb_n) && !a_wr_any) |=> !a_rdy);

    p_bidir_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_mode == 2'd2) |-> (a_oe == {W{!a_stb_n}}));

    p_b_no_bidir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        b_mode != 2'd2);

    p_bit_quiet_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (a_mode == 2'd3) |-> !a_rdy);

    p_bit_quiet_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (b_mode == 2'd3 && a_mode != 2'd2) |-> !b_rdy);
endmodule

bind ppio_ctrl ppio_ctrl_sva #(.W(W)) u_sva (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .sel_port(sel_port),
    .sel_cmd(sel_cmd), .a_stb_n(a_stb_n), .a_rdy(a_rdy), .b_rdy(b_rdy),
    .a_oe(a_oe), .b_oe(b_oe), .irq_a(irq_a), .irq_b(irq_b),
    .a_mode(a_mode), .b_mode(b_mode)
);

// File: tb/ppio_ctrl_test.sv
`timescale 1ns/1ps
module ppio_ctrl_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs = 1'b0, wr = 1'b0, rd = 1'b0, sel_port = 1'b0, sel_cmd = 1'b0;
    logic [W-1:0] wdata = '0, rdata;
    logic [W-1:0] a_in = '0, a_out, a_oe;
    logic [W-1:0] b_in = '0, b_out, b_oe;
    logic         a_stb_n = 1'b1, b_stb_n = 1'b1;
    logic         a_rdy, b_rdy, irq_a, irq_b;
    int           nchk = 0, nerr = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    ppio_ctrl #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd),
        .sel_port(sel_port), .sel_cmd(sel_cmd), .wdata(wdata), .rdata(rdata),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .a_stb_n(a_stb_n), .a_rdy(a_rdy),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .b_stb_n(b_stb_n), .b_rdy(b_rdy),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic port, input logic cmd, input logic [W-1:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; sel_port = port; sel_cmd = cmd; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic port, output logic [W-1:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; sel_port = port; sel_cmd = 1'b0;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic pulse_a();
        @(negedge clk); a_stb_n = 1'b0;
        @(negedge clk); a_stb_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [W-1:0] d;
        chk("R1 a_rdy", a_rdy, 0);
        chk("R1 b_rdy", b_rdy, 0);
        chk("R1 irq", {irq_a, irq_b}, 0);
        chk("R1 oe", {a_oe, b_oe}, 0);
        bus_rd(1'b0, d);
        chk("R1 input latch", d, 0);
        chk("R5 read arms rdy", a_rdy, 1);
    endtask

    task automatic t_output();
        bus_wr(1'b0, 1'b1, 8'h03);
        chk("R11 mode byte clears ready", a_rdy, 0);
        bus_wr(1'b0, 1'b1, 8'h81);
        bus_wr(1'b0, 1'b0, 8'h5A);
        chk("R3 rdy", a_rdy, 1);
        chk("R3 out", a_out, 8'h5A);
        chk("R3 oe", a_oe, 8'hFF);
        @(negedge clk); a_stb_n = 1'b0;
        @(negedge clk);
        chk("R4 rdy held while strobe low", a_rdy, 1);
        a_stb_n = 1'b1;
        @(negedge clk);
        chk("R4 rdy drops on rise", a_rdy, 0);
        chk("R4 irq on rise", irq_a, 1);
        bus_wr(1'b0, 1'b0, 8'h3C);
        chk("R10 write clears irq", irq_a, 0);
        bus_wr(1'b0, 1'b1, 8'h01);
        pulse_a();
        chk("R4 rdy drops, irq disabled", a_rdy, 0);
        chk("R4 no irq when disabled", irq_a, 0);
    endtask

    task automatic t_input();
        logic [W-1:0] d;
        bus_wr(1'b0, 1'b1, 8'h43);
        chk("R5 mode entry arms rdy", a_rdy, 1);
        bus_wr(1'b0, 1'b1, 8'h81);
        a_in = 8'hC3;
        @(negedge clk); a_stb_n = 1'b0;
        @(negedge clk); a_stb_n = 1'b1; a_in = 8'h11;
        @(negedge clk);
        chk("R5 rdy drops", a_rdy, 0);
        chk("R4 input irq", irq_a, 1);
        bus_rd(1'b0, d);
        chk("R5 latched data", d, 8'hC3);
        chk("R5 read re-arms", a_rdy, 1);
        chk("R10 read clears irq", irq_a, 0);
    endtask

    task automatic t_bidir();
        logic [W-1:0] d;
        bus_wr(1'b0, 1'b1, 8'h83);
        chk("R6 a_rdy output side", a_rdy, 0);
        chk("R6 b_rdy input side", b_rdy, 1);
        bus_wr(1'b1, 1'b1, 8'h03);
        chk("R7 port B mode 0 locked out", b_oe, 8'h00);
        bus_wr(1'b0, 1'b0, 8'h96);
        chk("R6 a_rdy after write", a_rdy, 1);
        chk("R6 no drive with strobe high", a_oe, 8'h00);
        @(negedge clk); a_stb_n = 1'b0;
        #1 chk("R6 drive while strobe low", a_oe, 8'hFF);
        chk("R6 out data", a_out, 8'h96);
        @(negedge clk); a_stb_n = 1'b1;
        @(negedge clk);
        chk("R6 a_rdy drops", a_rdy, 0);
        a_in = 8'h69;
        @(negedge clk); b_stb_n = 1'b0;
        @(negedge clk); b_stb_n = 1'b1; a_in = 8'h00;
        @(negedge clk);
        chk("R6 b_rdy drops on B strobe", b_rdy, 0);
        bus_rd(1'b0, d);
        chk("R6 B strobe latched A pins", d, 8'h69);
        chk("R6 b_rdy re-armed", b_rdy, 1);
        bus_wr(1'b1, 1'b1, 8'hC3);
        bus_wr(1'b1, 1'b1, 8'h0F);
        bus_wr(1'b1, 1'b1, 8'h00);
        chk("R7 bit-control accepted, R8 dir", b_oe, 8'hF0);
        bus_wr(1'b0, 1'b1, 8'h03);
        bus_wr(1'b1, 1'b1, 8'h83);
        chk("R7 port B bidir ignored", b_oe, 8'hF0);
    endtask

    task automatic t_bitctl();
        logic [W-1:0] d;
        bus_wr(1'b1, 1'b1, 8'hF3);
        bus_wr(1'b1, 1'b1, 8'h0F);
        bus_wr(1'b1, 1'b1, 8'h03);
        bus_wr(1'b1, 1'b1, 8'h81);
        bus_wr(1'b1, 1'b0, 8'hA5);
        chk("R8 b_out", b_out, 8'hA5);
        @(negedge clk); b_in = 8'h01;
        @(negedge clk);
        chk("R9 AND partial no irq", irq_b, 0);
        b_in = 8'h03;
        @(negedge clk);
        chk("R9 AND full match irq", irq_b, 1);
        bus_rd(1'b1, d);
        chk("R8 mixed read", d, 8'hA3);
        chk("R10 read clears irq B", irq_b, 0);
        chk("R11 bit mode ready low", b_rdy, 0);
        @(negedge clk); b_in = 8'h0F;
        bus_wr(1'b1, 1'b1, 8'hC3);
        bus_wr(1'b1, 1'b1, 8'h0F);
        bus_wr(1'b1, 1'b1, 8'h8C);
        @(negedge clk);
        chk("R9 output bit not watched", irq_b, 0);
        b_in = 8'h07;
        @(negedge clk);
        chk("R9 OR active low match", irq_b, 1);
    endtask

    task automatic t_cmd();
        bus_wr(1'b0, 1'b1, 8'h81);
        bus_wr(1'b0, 1'b0, 8'h11);
        bus_wr(1'b0, 1'b1, 8'h02);
        chk("R2 unknown byte keeps oe", a_oe, 8'hFF);
        chk("R2 unknown byte keeps rdy", a_rdy, 1);
        bus_wr(1'b0, 1'b1, 8'h03);
        chk("R11 same mode clears rdy", a_rdy, 0);
        bus_wr(1'b0, 1'b0, 8'h22);
        pulse_a();
        chk("R2 irq pending", irq_a, 1);
        bus_wr(1'b0, 1'b1, 8'h01);
        chk("R2 disable drops irq", irq_a, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_output();
        t_input();
        t_bidir();
        t_bitctl();
        t_cmd();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule